// File: doc/BRIEF.md
# Keyed Address Bit Permuter

This block hides the layout of an address on its way to untrusted external memory. It moves the address bits around through a rearrangeable network of 2x2 crossbar switches. The network has a Benes structure: an outer column of N/2 switches, two half-size networks, then a second outer column. A configuration word selects the permutation, with one bit per switch. A select input chooses the direction. Scramble sends the address through the columns from input to output. Descramble applies the same switch settings with the columns taken in reverse order, so a scrambled address comes back exactly.

The path from address to output is purely combinational and adds no cycles. The configuration is held in two registers. A shadow register accepts a new word at any time. An active register drives the network. The shadow word moves into the active register only when the update strobe is asserted and no access is in flight. This keeps the mapping unchanged while memory traffic depends on it.

Top module: `addr_permuter`

## Requirements
- R1: After reset both configuration registers hold all zeros, so the output equals the input address in either direction.
- R2: The output follows a change of the address or of the direction select in the same clock cycle, with no register on the path.
- R3: The network has 2·log2(N)−1 columns of N/2 switches; the column at stage c pairs bits at distance 2^k, with k = |log2(N)−1−c|. Switch s of column c is controlled by configuration bit c·(N/2)+s and pairs bit lo = ((s>>k)<<(k+1)) | (s mod 2^k) with bit lo+2^k. A control bit of 0 passes both bits straight through and a 1 swaps them. Scramble (direction select 0) applies the columns in the order 0, 1, 2 and so on. For N = 32: bit 0 alone maps address bit 0 to bit 16, bit 64 alone maps bit 0 to bit 1, and bit 131 alone maps bit 3 to bit 19.
- R4: For any configuration and address, descrambling the scrambled address returns the original address.
- R5: For every configuration the mapping is a bit permutation: each one-hot address gives a one-hot output, all N outputs are distinct, and the number of set bits is preserved.
- R6: Descramble (direction select 1) applies the same switch bits with the columns in reverse order, from the last column to column 0.
- R7: A load pulse writes the configuration input into the shadow register at the next clock edge. It has no effect on the output until a commit.
- R8: A commit while the in-flight flag is low copies the shadow register into the active register at the next clock edge.
- R9: A commit while the in-flight flag is high is ignored, and the active configuration stays as it was.
- R10: When load and an accepted commit happen in the same cycle, the active register takes the previous shadow value and the shadow register takes the new input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | N | Address to be permuted |
| dir_i | input | 1 | 0 = scramble, 1 = descramble |
| cfg_i | input | (2·log2(N)−1)·N/2 | New switch configuration word |
| cfg_load_i | input | 1 | Write cfg_i into the shadow register |
| cfg_commit_i | input | 1 | Request to move the shadow word into the active register |
| busy_i | input | 1 | Access in flight; blocks a commit |
| addr_o | output | N | Permuted address |

## Verification
A wrong switch bit or a mis-wired column shows up at once. The output differs from the reference permutation in the same cycle as the address that crosses it. A scramble followed by a descramble then no longer gives the original address. A fault in the configuration holder only shows after the clock edge that should, or should not, have changed the active word. The bench therefore keeps the old and new configurations different and applies an address in the cycle right after each load or commit. Any early or missed update then appears as a wrong address.

// File: rtl/perm_pkg.sv
package perm_pkg;

    typedef enum logic {
        DIR_SCRAMBLE   = 1'b0,
        DIR_DESCRAMBLE = 1'b1
    } perm_dir_e;

    // number of configuration bits for an n-wide network
    function automatic int cfg_bits(input int n);
        return (2 * $clog2(n) - 1) * (n / 2);
    endfunction

    // log2 of the pairing distance used by column col of a 2^m network
    function automatic int pair_exp(input int col, input int m);
        return (col < m - 1) ? (m - 1 - col) : (col - (m - 1));
    endfunction

    // lower lane index of switch s in a column with pairing distance 2^k
    function automatic int pair_lo(input int s, input int k);
        return ((s >> k) << (k + 1)) | (s & ((1 << k) - 1));
    endfunction

endpackage

// File: rtl/swap_column.sv
module swap_column
    import perm_pkg::*;
#(
    parameter int N = 32,
    parameter int K = 0
) (
    input  logic [N/2-1:0] sel_i,
    input  logic [N-1:0]   din_i,
    output logic [N-1:0]   dout_o
);
    localparam int SW   = N / 2;
    localparam int DIST = 1 << K;

    for (genvar s = 0; s < SW; s++) begin : g_sw
        localparam int LO = pair_lo(s, K);
        localparam int HI = LO + DIST;
        assign dout_o[LO] = sel_i[s] ? din_i[HI] : din_i[LO];
        assign dout_o[HI] = sel_i[s] ? din_i[LO] : din_i[HI];
    end
endmodule

// File: rtl/benes_net.sv
module benes_net
    import perm_pkg::*;
#(
    parameter int N = 32
) (
    input  logic                   descr_i,
    input  logic [cfg_bits(N)-1:0] cfg_i,
    input  logic [N-1:0]           din_i,
    output logic [N-1:0]           dout_o
);
    localparam int M    = $clog2(N);
    localparam int COLS = 2 * M - 1;
    localparam int SW   = N / 2;

    logic [N-1:0] lane [COLS+1];

    assign lane[0] = din_i;

    for (genvar t = 0; t < COLS; t++) begin : g_stage
        localparam int FWD = t;
        localparam int REV = COLS - 1 - t;
        logic [SW-1:0] sel;
        // both column orders use the same distance at stage t (symmetric layout)
        assign sel = descr_i ? cfg_i[REV*SW +: SW] : cfg_i[FWD*SW +: SW];
        swap_column #(
            .N (N),
            .K (pair_exp(t, M))
        ) u_col (
            .sel_i  (sel),
            .din_i  (lane[t]),
            .dout_o (lane[t+1])
        );
    end

    assign dout_o = lane[COLS];
endmodule

// File: rtl/cfg_holder.sv
module cfg_holder #(
    parameter int W = 144
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] din_i,
    input  logic         commit_i,
    input  logic         busy_i,
    output logic [W-1:0] shadow_o,
    output logic [W-1:0] active_o
);
    typedef struct packed {
        logic [W-1:0] shadow;
        logic [W-1:0] active;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit_i && !busy_i) begin
            st_d.active = st_q.shadow;
        end
        if (load_i) begin
            st_d.shadow = din_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shadow_o = st_q.shadow;
    assign active_o = st_q.active;
endmodule

// File: rtl/addr_permuter.sv
module addr_permuter
    import perm_pkg::*;
#(
    parameter int N = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           addr_i,
    input  logic                   dir_i,
    input  logic [cfg_bits(N)-1:0] cfg_i,
    input  logic                   cfg_load_i,
    input  logic                   cfg_commit_i,
    input  logic                   busy_i,
    output logic [N-1:0]           addr_o
);
    localparam int CFG_W = cfg_bits(N);

    perm_dir_e        dir;
    logic [CFG_W-1:0] cfg_shadow;
    logic [CFG_W-1:0] cfg_active;

    assign dir = perm_dir_e'(dir_i);

    cfg_holder #(
        .W (CFG_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (cfg_load_i),
        .din_i    (cfg_i),
        .commit_i (cfg_commit_i),
        .busy_i   (busy_i),
        .shadow_o (cfg_shadow),
        .active_o (cfg_active)
    );

    benes_net #(
        .N (N)
    ) u_net (
        .descr_i (dir == DIR_DESCRAMBLE),
        .cfg_i   (cfg_active),
        .din_i   (addr_i),
        .dout_o  (addr_o)
    );
endmodule

// File: rtl/perm_chk.sv
module perm_chk #(
    parameter int N  = 32,
    parameter int CW = 144
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  addr_i,
    input logic [N-1:0]  addr_o,
    input logic [CW-1:0] cfg_i,
    input logic          cfg_load_i,
    input logic          cfg_commit_i,
    input logic          busy_i,
    input logic [CW-1:0] shadow,
    input logic [CW-1:0] active
);
    AST_ZERO_CFG_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |-> (addr_o == addr_i)); // R1

    AST_WEIGHT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(addr_o) == $countones(addr_i)); // R5

    AST_LOAD_TO_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load_i |=> (shadow == $past(cfg_i))); // R7

    AST_IDLE_ACTIVE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_commit_i |=> $stable(active)); // R7

    AST_COMMIT_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_commit_i && !busy_i) |=> (active == $past(shadow))); // R8

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_commit_i && busy_i) |=> $stable(active)); // R9

    AST_SAME_CYCLE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load_i && cfg_commit_i && !busy_i) |=> (active == $past(shadow) && shadow == $past(cfg_i))); // R10
endmodule

bind addr_permuter perm_chk #(
    .N  (N),
    .CW (CFG_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_i       (addr_i),
    .addr_o       (addr_o),
    .cfg_i        (cfg_i),
    .cfg_load_i   (cfg_load_i),
    .cfg_commit_i (cfg_commit_i),
    .busy_i       (busy_i),
    .shadow       (cfg_shadow),
    .active       (cfg_active)
);

// File: tb/tb_addr_permuter.sv
module tb_addr_permuter;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 32;
    localparam int CW = 144;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [N-1:0]  addr_i = '0;
    logic          dir_i = 0;
    logic [CW-1:0] cfg_i = '0;
    logic          cfg_load_i = 0;
    logic          cfg_commit_i = 0;
    logic          busy_i = 0;
    logic [N-1:0]  addr_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [CW-1:0] exp_shadow = '0;
    logic [CW-1:0] exp_active = '0;

    logic [N-1:0] q_exp [$];
    string        q_tag [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_permuter #(.N(N)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_i       (addr_i),
        .dir_i        (dir_i),
        .cfg_i        (cfg_i),
        .cfg_load_i   (cfg_load_i),
        .cfg_commit_i (cfg_commit_i),
        .busy_i       (busy_i),
        .addr_o       (addr_o)
    );

    // reference permutation written from the column rules of the requirements
    function automatic logic [N-1:0] ref_perm(input logic [N-1:0] a,
                                              input logic [CW-1:0] c,
                                              input logic d);
        logic [N-1:0] v;
        v = a;
        for (int t = 0; t < 9; t++) begin
            int col;
            int k;
            col = d ? 8 - t : t;
            k = (col < 4) ? 4 - col : col - 4;
            for (int s = 0; s < 16; s++) begin
                int lo;
                int hi;
                logic tmp;
                lo = ((s >> k) << (k + 1)) | (s & ((1 << k) - 1));
                hi = lo + (1 << k);
                if (c[col*16 + s]) begin
                    tmp   = v[lo];
                    v[lo] = v[hi];
                    v[hi] = tmp;
                end
            end
        end
        return v;
    endfunction

    function automatic logic [CW-1:0] rand_cfg();
        return {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: apply one address per cycle and queue the expected result
    task automatic drive_exp(input logic [N-1:0] a, input logic d,
                             input logic [N-1:0] e, input string tag);
        @(posedge clk);
        #1;
        addr_i = a;
        dir_i  = d;
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    task automatic drive(input logic [N-1:0] a, input logic d, input string tag);
        drive_exp(a, d, ref_perm(a, exp_active, d), tag);
    endtask

    // monitor: compare mid-cycle, away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (q_exp.size() > 0) begin
                logic [N-1:0] e;
                string tg;
                e  = q_exp.pop_front();
                tg = q_tag.pop_front();
                check(tg, addr_o, e);
            end
        end
    end

    task automatic load_cfg(input logic [CW-1:0] v);
        @(posedge clk);
        #1;
        cfg_i = v;
        cfg_load_i = 1;
        @(posedge clk);
        #1;
        cfg_load_i = 0;
        exp_shadow = v;
    endtask

    task automatic commit(input logic b);
        @(posedge clk);
        #1;
        cfg_commit_i = 1;
        busy_i = b;
        @(posedge clk);
        #1;
        cfg_commit_i = 0;
        busy_i = 0;
        if (!b) exp_active = exp_shadow;
    endtask

    task automatic load_and_commit(input logic [CW-1:0] v);
        @(posedge clk);
        #1;
        cfg_i = v;
        cfg_load_i = 1;
        cfg_commit_i = 1;
        @(posedge clk);
        #1;
        cfg_load_i = 0;
        cfg_commit_i = 0;
        exp_active = exp_shadow;
        exp_shadow = v;
    endtask

    task automatic use_cfg(input logic [CW-1:0] v);
        load_cfg(v);
        commit(1'b0);
    endtask

    // R5: every one-hot input lands on a distinct single bit
    task automatic bijection_scan();
        logic [N-1:0] seen;
        logic         all_onehot;
        seen = '0;
        all_onehot = 1;
        for (int i = 0; i < N; i++) begin
            @(posedge clk);
            #1;
            addr_i = N'(1) << i;
            dir_i  = 0;
            #1;
            if (!$onehot(addr_o)) all_onehot = 0;
            seen = seen | addr_o;
        end
        check("R5 one-hot images", {31'd0, all_onehot}, 32'd1);
        check("R5 images cover all bits", seen, '1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] c_old;
        logic [CW-1:0] c_new;
        logic [CW-1:0] c_third;

        // R1: identity during and after reset
        drive_exp(32'hDEAD_BEEF, 0, 32'hDEAD_BEEF, "R1 reset scramble");
        drive_exp(32'h1234_5678, 1, 32'h1234_5678, "R1 reset descramble");
        @(posedge clk);
        #1;
        rst_n = 1;
        drive_exp(32'hA5A5_0F0F, 0, 32'hA5A5_0F0F, "R1 after reset");

        // R3: single-switch configurations with hand-derived results
        use_cfg(144'd1);
        drive_exp(32'h0000_0001, 0, 32'h0001_0000, "R3 col0 sw0");
        use_cfg(144'd1 << 64);
        drive_exp(32'h0000_0001, 0, 32'h0000_0002, "R3 col4 sw0");
        use_cfg(144'd1 << 131);
        drive_exp(32'h0000_0008, 0, 32'h0008_0000, "R3 col8 sw3");
        drive_exp(32'h0008_0000, 1, 32'h0000_0008, "R6 single switch inverse");

        // R2: back-to-back address and direction changes, same-cycle output
        use_cfg(rand_cfg());
        for (int i = 0; i < 8; i++) drive($urandom(), i[0], "R2 same-cycle follow");

        // R3, R4, R6, R5 across random configurations
        for (int j = 0; j < 24; j++) begin
            use_cfg(rand_cfg());
            for (int i = 0; i < 6; i++) begin
                logic [N-1:0] a;
                a = $urandom();
                drive(a, 0, "R3 scramble model");
                drive_exp(ref_perm(a, exp_active, 0), 1, a, "R4 round trip");
                drive(a, 1, "R6 descramble model");
            end
            bijection_scan();
        end

        // R7: loading without commit leaves the mapping unchanged
        c_old = 144'd1;
        c_new = 144'd1 << 64;
        use_cfg(c_old);
        load_cfg(c_new);
        drive_exp(32'h0000_0001, 0, 32'h0001_0000, "R7 load has no effect");

        // R9: commit while busy is ignored
        commit(1'b1);
        drive_exp(32'h0000_0001, 0, 32'h0001_0000, "R9 busy blocks commit");

        // R8: commit while idle takes effect
        commit(1'b0);
        drive_exp(32'h0000_0001, 0, 32'h0000_0002, "R8 commit applies");

        // R10: load and commit together take the old shadow value
        c_third = 144'd1 << 131;
        load_cfg(c_old);
        load_and_commit(c_third);
        drive_exp(32'h0000_0001, 0, 32'h0001_0000, "R10 previous shadow active");
        commit(1'b0);
        drive_exp(32'h0000_0008, 0, 32'h0008_0000, "R10 new shadow kept");

        @(posedge clk);
        @(posedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule